// File: doc/BRIEF.md
# Decode-Stage Interlock for an In-Order Pipeline with Two FP Units

This block decides, every cycle, whether the instruction sitting in the decode stage of an in-order five-stage pipeline (fetch, decode, execute, memory, writeback) may move into execute. The pipeline carries two floating-point execution units that are not pipelined. One handles add and subtract and is occupied for `ADD_LAT` cycles. The other handles multiply and divide and is occupied for `MUL_LAT` cycles. Integer and load results pass through the normal execute and memory stages. Full bypassing is present, so a consumer waits only until its operand can be forwarded, not until writeback.

The decode stage presents an operation class, up to two source registers and one destination register. Each register comes with a use flag and a flag that selects the integer or FP register file. The block keeps its own record of every instruction it has let through. For each register in each file, a small counter holds the number of cycles until that register's latest value is written back. For each FP unit, a counter holds the remaining occupancy. From these it produces a decode stall, a fetch hold and a bubble request for execute. It also produces a bypass select per source and a code that gives the reason for a stall. Branch delay is not modelled.

Top module: `fp_interlock`

## Requirements
- R1: After reset, and after a reset applied in the middle of a run, no register is pending and neither FP unit is busy: a valid instruction stalls for zero cycles and both bypass selects read 0.
- R2: Let D be the distance in issue cycles between a producer and a consumer that reads its destination. The consumer is held until D reaches 1 for an ALU op, 2 for a load, `ADD_LAT` for an FP add and `MUL_LAT` for an FP multiply. With the defaults, three cases follow. A multiply that uses a just-loaded register stalls 1 cycle. An add that depends on a multiply two instructions back stalls 3 cycles. A store whose data comes from the immediately preceding FP add stalls 1 cycle.
- R3: Bypass select codes are 0 = register file, 1 = end-of-execute latch and 2 = end-of-memory latch. Let W be the producer's writeback distance: 3 for ALU and load, `ADD_LAT`+2 for FP add and `MUL_LAT`+2 for FP multiply. A consumer issuing at distance D gets 0 if D >= W, 2 if D = W-1, and 1 otherwise. A source whose use flag is low always gets 0.
- R4: A loaded value is never taken from the end-of-execute latch. A consumer at distance 2 gets select 2, and one at distance 3 gets select 0.
- R5: Each FP unit accepts a new operation of its own class only once its previous one has left execute. A second multiply waits until `MUL_LAT` issue cycles after the first, and a second add waits until `ADD_LAT` after the first. Operations of the other class and integer ops are not delayed by a busy unit.
- R6: An instruction whose destination still has an older write in flight waits until its own writeback would come strictly after the older one. With the defaults, an add writing the multiply's destination right after it waits 3 cycles, and a load writing it waits 4 cycles.
- R7: `stall_cause` encodes 0 = none, 1 = busy FP unit, 2 = source not yet forwardable and 3 = destination write ordering. When several apply, the lowest nonzero code wins. The code is 0 in any cycle without a stall.
- R8: `hold_if` and `bubble_ex` equal `stall_id` in every cycle, and `stall_id` is only ever high while `id_valid` is high.
- R9: Integer register 0 is never recorded as pending. A read of it right after an ALU op or a load that names it as destination stalls 0 cycles and gets select 0.
- R10: Only issued instructions change state. The following leave no pending register and no busy unit behind: an instruction with `id_valid` low, a destination whose use flag is low, and a store's destination fields. Operation codes are ALU 0, load 1, store 2, FP add 3 and FP multiply 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_op | input | 3 | Operation class (0 ALU, 1 load, 2 store, 3 FP add, 4 FP multiply) |
| id_src_a | input | REG_W | First source register number |
| id_src_a_fp | input | 1 | First source is in the FP file |
| id_src_a_use | input | 1 | First source is read |
| id_src_b | input | REG_W | Second source register number |
| id_src_b_fp | input | 1 | Second source is in the FP file |
| id_src_b_use | input | 1 | Second source is read |
| id_dst | input | REG_W | Destination register number |
| id_dst_fp | input | 1 | Destination is in the FP file |
| id_dst_use | input | 1 | Destination is written |
| stall_id | output | 1 | Hold the decode instruction this cycle |
| hold_if | output | 1 | Hold the fetch stage this cycle |
| bubble_ex | output | 1 | Inject a bubble into execute this cycle |
| fwd_sel_a | output | 2 | Bypass select for the first source |
| fwd_sel_b | output | 2 | Bypass select for the second source |
| stall_cause | output | 2 | Reason for the current stall |

## Verification
The bench sweeps every producer class against a dependent store at zero to six intervening instructions, in both source slots. This catches an off-by-one latency, which shows up as one stall too many or too few. It also catches a load forwarded from the end-of-execute latch, which would deliver an address instead of the data. Back-to-back operations of the same FP class, swept over the same distances, expose a unit whose busy time is short by a cycle and so accepts an operation while still occupied. Destination-reordering cases aim at a design that simply overwrites the pending counter, which lets a later reader pick up a value that the older, slower write then clobbers. Priority cases, register 0, ignored fields and a mid-run reset show up as wrong cause codes, false stalls or stalls left behind by stale state.

// File: rtl/fpil_pkg.sv
// Package: shared encodings for the decode-stage interlock.
// Assumes the codes below are fixed by the decode stage and the bypass muxes.
package fpil_pkg;

    typedef enum logic [2:0] {
        OP_ALU   = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_FADD  = 3'd3,
        OP_FMUL  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_UNIT = 2'd1,
        CAUSE_RAW  = 2'd2,
        CAUSE_WAW  = 2'd3
    } cause_e;

    localparam logic [1:0] FWD_RF  = 2'd0;
    localparam logic [1:0] FWD_EXM = 2'd1;
    localparam logic [1:0] FWD_MWB = 2'd2;

endpackage

// File: rtl/fpil_scoreboard.sv
// Module: per-register countdown table for one register file.
// Each entry counts cycles until the register's newest value is written
// back; a flag marks values that only exist after the memory stage.
// Assumes the caller writes an entry only for an instruction that issues.
module fpil_scoreboard #(
    parameter int NREGS     = 32,
    parameter int CNT_W     = 3,
    parameter bit HARD_ZERO = 1'b0,
    localparam int IDX_W    = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             wr_mem,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [CNT_W-1:0] rd_a_cnt,
    output logic             rd_a_mem,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [CNT_W-1:0] rd_b_cnt,
    output logic             rd_b_mem,
    input  logic [IDX_W-1:0] rd_d_idx,
    output logic [CNT_W-1:0] rd_d_cnt
);

    logic [CNT_W-1:0] cnt_q [NREGS];
    logic             mem_q [NREGS];

    // Load a new countdown on issue, otherwise count every live entry down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                cnt_q[i] <= '0;
                mem_q[i] <= 1'b0;
            end
        end else begin
            for (int i = 0; i < NREGS; i++) begin
                if (wr_en && wr_idx == IDX_W'(i) && !(HARD_ZERO && i == 0)) begin
                    cnt_q[i] <= wr_cnt;
                    mem_q[i] <= wr_mem;
                end else if (cnt_q[i] != '0) begin
                    cnt_q[i] <= cnt_q[i] - 1'b1;
                end
            end
        end
    end

    // Read ports for the two sources and the destination.
    assign rd_a_cnt = cnt_q[rd_a_idx];
    assign rd_a_mem = mem_q[rd_a_idx];
    assign rd_b_cnt = cnt_q[rd_b_idx];
    assign rd_b_mem = mem_q[rd_b_idx];
    assign rd_d_cnt = cnt_q[rd_d_idx];

    // R2
    record_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(HARD_ZERO && wr_idx == '0)) |=> cnt_q[$past(wr_idx)] == $past(wr_cnt));

    generate
        if (HARD_ZERO) begin : g_zero_chk
            // R9
            zero_reg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx == '0) |=> cnt_q[0] == '0);
        end
    endgenerate

endmodule

// File: rtl/fpil_unit_busy.sv
// Module: occupancy counter for one non-pipelined execution unit.
// Assumes start is raised only on the cycle an operation leaves decode,
// and that the operation then holds execute for OCC cycles.
module fpil_unit_busy #(
    parameter int OCC    = 5,
    localparam int BCW   = $clog2(OCC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    logic [BCW-1:0] left_q;

    // Reload on start, then count down the remaining occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (start)
            left_q <= BCW'(OCC - 1);
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign busy = (left_q != '0);

    // R5
    unit_free_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> left_q == '0);

endmodule

// File: rtl/fpil_src_check.sv
// Module: decides for one source operand whether it can be forwarded now
// and from where. The countdown gives cycles to writeback: 2 means the value
// sits at the end of execute, 1 at the end of memory, 0 in the file.
// Assumes values flagged as memory-produced do not exist at end of execute.
module fpil_src_check #(
    parameter int CNT_W = 3
) (
    input  logic             use_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             mem_i,
    output logic             hold_o,
    output logic [1:0]       sel_o
);
    import fpil_pkg::*;

    localparam logic [CNT_W-1:0] AT_EX  = CNT_W'(2);
    localparam logic [CNT_W-1:0] AT_MEM = CNT_W'(1);

    // Hold while the value has not reached a forwarding point.
    always_comb begin
        hold_o = use_i && ((cnt_i > AT_EX) || (cnt_i == AT_EX && mem_i));
    end

    // Pick the bypass source from the remaining distance to writeback.
    always_comb begin
        if (!use_i)
            sel_o = FWD_RF;
        else if (cnt_i == AT_EX)
            sel_o = FWD_EXM;
        else if (cnt_i == AT_MEM)
            sel_o = FWD_MWB;
        else
            sel_o = FWD_RF;
    end

endmodule

// File: rtl/fp_interlock.sv
// Module: decode-stage interlock for an in-order five-stage pipeline with a
// non-pipelined FP adder and FP multiplier. Tracks every issued instruction
// itself, so it needs only the decode fields. Checks, in priority order,
// busy FP unit, unforwardable source and destination write ordering.
// Assumes one instruction leaves decode per cycle and 2 <= ADD_LAT <= MUL_LAT.
module fp_interlock #(
    parameter int NUM_REGS = 32,
    parameter int ADD_LAT  = 2,
    parameter int MUL_LAT  = 5,
    localparam int REG_W   = $clog2(NUM_REGS),
    localparam int MAXLAT  = (MUL_LAT > ADD_LAT) ? MUL_LAT : ADD_LAT,
    localparam int CNT_W   = $clog2(MAXLAT + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_valid,
    input  logic [2:0]       id_op,
    input  logic [REG_W-1:0] id_src_a,
    input  logic             id_src_a_fp,
    input  logic             id_src_a_use,
    input  logic [REG_W-1:0] id_src_b,
    input  logic             id_src_b_fp,
    input  logic             id_src_b_use,
    input  logic [REG_W-1:0] id_dst,
    input  logic             id_dst_fp,
    input  logic             id_dst_use,
    output logic             stall_id,
    output logic             hold_if,
    output logic             bubble_ex,
    output logic [1:0]       fwd_sel_a,
    output logic [1:0]       fwd_sel_b,
    output logic [1:0]       stall_cause
);
    import fpil_pkg::*;

    op_e              op;
    logic             dst_wr;
    logic [CNT_W-1:0] new_cnt;
    logic             new_mem;
    logic             issue;
    logic             unit_hz, raw_hz, waw_hz;
    cause_e           cause;

    logic [CNT_W-1:0] i_a_cnt, i_b_cnt, i_d_cnt, f_a_cnt, f_b_cnt, f_d_cnt;
    logic             i_a_mem, i_b_mem, f_a_mem, f_b_mem;
    logic [CNT_W-1:0] a_cnt, b_cnt, d_cnt;
    logic             a_mem, b_mem;
    logic             a_hold, b_hold;
    logic             add_busy, mul_busy;

    assign op = op_e'(id_op);

    // Writeback distance and memory-only flag of the decode instruction.
    always_comb begin
        dst_wr  = id_dst_use && (op != OP_STORE);
        new_mem = 1'b0;
        case (op)
            OP_ALU:  new_cnt = CNT_W'(2);
            OP_LOAD: begin new_cnt = CNT_W'(2); new_mem = 1'b1; end
            OP_FADD: new_cnt = CNT_W'(ADD_LAT + 1);
            OP_FMUL: new_cnt = CNT_W'(MUL_LAT + 1);
            default: new_cnt = '0;
        endcase
    end

    // One table per register file; only the integer file hardwires entry 0.
    fpil_scoreboard #(.NREGS(NUM_REGS), .CNT_W(CNT_W), .HARD_ZERO(1'b1)) u_sb_int (
        .clk(clk), .rst_n(rst_n),
        .wr_en(issue && dst_wr && !id_dst_fp), .wr_idx(id_dst),
        .wr_cnt(new_cnt), .wr_mem(new_mem),
        .rd_a_idx(id_src_a), .rd_a_cnt(i_a_cnt), .rd_a_mem(i_a_mem),
        .rd_b_idx(id_src_b), .rd_b_cnt(i_b_cnt), .rd_b_mem(i_b_mem),
        .rd_d_idx(id_dst),   .rd_d_cnt(i_d_cnt)
    );

    fpil_scoreboard #(.NREGS(NUM_REGS), .CNT_W(CNT_W), .HARD_ZERO(1'b0)) u_sb_fp (
        .clk(clk), .rst_n(rst_n),
        .wr_en(issue && dst_wr && id_dst_fp), .wr_idx(id_dst),
        .wr_cnt(new_cnt), .wr_mem(new_mem),
        .rd_a_idx(id_src_a), .rd_a_cnt(f_a_cnt), .rd_a_mem(f_a_mem),
        .rd_b_idx(id_src_b), .rd_b_cnt(f_b_cnt), .rd_b_mem(f_b_mem),
        .rd_d_idx(id_dst),   .rd_d_cnt(f_d_cnt)
    );

    // Choose each operand's entry from the file it names.
    always_comb begin
        a_cnt = id_src_a_fp ? f_a_cnt : i_a_cnt;
        a_mem = id_src_a_fp ? f_a_mem : i_a_mem;
        b_cnt = id_src_b_fp ? f_b_cnt : i_b_cnt;
        b_mem = id_src_b_fp ? f_b_mem : i_b_mem;
        d_cnt = id_dst_fp   ? f_d_cnt : i_d_cnt;
    end

    fpil_src_check #(.CNT_W(CNT_W)) u_chk_a (
        .use_i(id_src_a_use), .cnt_i(a_cnt), .mem_i(a_mem),
        .hold_o(a_hold), .sel_o(fwd_sel_a)
    );

    fpil_src_check #(.CNT_W(CNT_W)) u_chk_b (
        .use_i(id_src_b_use), .cnt_i(b_cnt), .mem_i(b_mem),
        .hold_o(b_hold), .sel_o(fwd_sel_b)
    );

    fpil_unit_busy #(.OCC(ADD_LAT)) u_add_busy (
        .clk(clk), .rst_n(rst_n),
        .start(issue && op == OP_FADD), .busy(add_busy)
    );

    fpil_unit_busy #(.OCC(MUL_LAT)) u_mul_busy (
        .clk(clk), .rst_n(rst_n),
        .start(issue && op == OP_FMUL), .busy(mul_busy)
    );

    // Hazard terms and their priority: unit, then source, then ordering.
    always_comb begin
        unit_hz = (op == OP_FADD && add_busy) || (op == OP_FMUL && mul_busy);
        raw_hz  = a_hold || b_hold;
        waw_hz  = dst_wr && (d_cnt > new_cnt);
        if (!id_valid)    cause = CAUSE_NONE;
        else if (unit_hz) cause = CAUSE_UNIT;
        else if (raw_hz)  cause = CAUSE_RAW;
        else if (waw_hz)  cause = CAUSE_WAW;
        else              cause = CAUSE_NONE;
    end

    // Drive the pipeline controls from the chosen cause.
    always_comb begin
        stall_id    = (cause != CAUSE_NONE);
        hold_if     = stall_id;
        bubble_ex   = stall_id;
        stall_cause = cause;
        issue       = id_valid && !stall_id;
    end

    // R5
    mul_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == OP_FMUL) |=> (!(id_valid && id_op == 3'(OP_FMUL)) || stall_id));

    // R2
    src_forwardable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (!(id_src_a_use && a_cnt > CNT_W'(2)) && !(id_src_b_use && b_cnt > CNT_W'(2))));

    // R6
    wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dst_wr) |-> d_cnt <= new_cnt);

endmodule

// File: tb/fp_interlock_bench.sv
// Bench: sweeps producer/consumer distances, unit reuse, write ordering and
// priority cases; expectations come from the latency arithmetic alone.
module fp_interlock_bench;
    import fpil_pkg::*;

    localparam int ADD_LAT = 2;
    localparam int MUL_LAT = 5;
    localparam int REG_W   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic id_valid = 1'b0;
    logic [2:0] id_op = '0;
    logic [REG_W-1:0] id_src_a = '0, id_src_b = '0, id_dst = '0;
    logic id_src_a_fp = 0, id_src_a_use = 0, id_src_b_fp = 0, id_src_b_use = 0;
    logic id_dst_fp = 0, id_dst_use = 0;
    logic stall_id, hold_if, bubble_ex;
    logic [1:0] fwd_sel_a, fwd_sel_b, stall_cause;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fp_interlock #(.NUM_REGS(32), .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) u_fp_interlock (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_op(id_op),
        .id_src_a(id_src_a), .id_src_a_fp(id_src_a_fp), .id_src_a_use(id_src_a_use),
        .id_src_b(id_src_b), .id_src_b_fp(id_src_b_fp), .id_src_b_use(id_src_b_use),
        .id_dst(id_dst), .id_dst_fp(id_dst_fp), .id_dst_use(id_dst_use),
        .stall_id(stall_id), .hold_if(hold_if), .bubble_ex(bubble_ex),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .stall_cause(stall_cause)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Present one instruction, wait until it leaves decode, report stalls.
    task automatic send(input op_e op, input int ai, input bit af, input bit au,
                        input int bi, input bit bf, input bit bu,
                        input int di, input bit df, input bit du,
                        output int stalls, output int cause0,
                        output int sa, output int sb, output int icyc);
        @(negedge clk);
        id_valid = 1'b1; id_op = op;
        id_src_a = REG_W'(ai); id_src_a_fp = af; id_src_a_use = au;
        id_src_b = REG_W'(bi); id_src_b_fp = bf; id_src_b_use = bu;
        id_dst = REG_W'(di); id_dst_fp = df; id_dst_use = du;
        #1;
        stalls = 0; cause0 = 0;
        while (stall_id && stalls < 40) begin
            if (stalls == 0) cause0 = int'(stall_cause);
            if (hold_if !== 1'b1 || bubble_ex !== 1'b1) chk("R8 hold/bubble during stall", 0, 1);
            stalls++;
            @(negedge clk); #1;
        end
        chk("R8 hold_if low at issue", int'(hold_if), 0);
        chk("R7 cause zero at issue", int'(stall_cause), 0);
        sa = int'(fwd_sel_a); sb = int'(fwd_sel_b); icyc = cyc;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        id_valid = 1'b0; id_op = '0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; id_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic filler(input int j);
        int s, c, x, y, t;
        send(OP_ALU, 0, 0, 0, 0, 0, 0, 10 + j, 0, 1, s, c, x, y, t);
        chk("R2 independent filler stalls", s, 0);
    endtask

    function automatic int ready_dist(input int k);
        case (k)
            0: return 1;
            1: return 2;
            2: return ADD_LAT;
            default: return MUL_LAT;
        endcase
    endfunction

    function automatic int wb_dist(input int k);
        case (k)
            0, 1: return 3;
            2: return ADD_LAT + 2;
            default: return MUL_LAT + 2;
        endcase
    endfunction

    function automatic op_e kind_op(input int k);
        case (k)
            0: return OP_ALU;
            1: return OP_LOAD;
            2: return OP_FADD;
            default: return OP_FMUL;
        endcase
    endfunction

    initial begin
        int s, c, sa, sb, t0, t1, d, exp_s, exp_sel;
        do_reset();

        // R1: clean state after reset
        send(OP_STORE, 4, 0, 1, 4, 1, 1, 0, 0, 0, s, c, sa, sb, t0);
        chk("R1 stalls after reset", s, 0);
        chk("R1 sel a after reset", sa, 0);
        chk("R1 sel b after reset", sb, 0);
        idle(2);

        // R2 R3 R4: producer class x distance x source slot
        for (int k = 0; k < 4; k++) begin
            for (int g = 0; g < 7; g++) begin
                for (int slot = 0; slot < 2; slot++) begin
                    int reg_n;
                    bit fp;
                    reg_n = (k == 0) ? 5 : 4;
                    fp = (k != 0);
                    if (k == 1)
                        send(OP_LOAD, 1, 0, 1, 0, 0, 0, 4, 1, 1, s, c, sa, sb, t0);
                    else
                        send(kind_op(k), 2, fp, 1, 3, fp, 1, reg_n, fp, 1, s, c, sa, sb, t0);
                    for (int j = 0; j < g; j++) filler(j);
                    if (slot == 0)
                        send(OP_STORE, reg_n, fp, 1, reg_n, fp, 0, 0, 0, 0, s, c, sa, sb, t1);
                    else
                        send(OP_STORE, reg_n, fp, 0, reg_n, fp, 1, 0, 0, 0, s, c, sa, sb, t1);
                    exp_s = ready_dist(k) - (g + 1);
                    if (exp_s < 0) exp_s = 0;
                    d = t1 - t0;
                    if (d >= wb_dist(k)) exp_sel = 0;
                    else if (d == wb_dist(k) - 1) exp_sel = 2;
                    else exp_sel = 1;
                    chk("R2 RAW stall count", s, exp_s);
                    if (exp_s > 0) chk("R7 RAW cause", c, 2);
                    if (k == 1) chk("R4 load bypass source", (slot == 0) ? sa : sb, exp_sel);
                    else chk("R3 bypass select", (slot == 0) ? sa : sb, exp_sel);
                    chk("R3 unused source reads file", (slot == 0) ? sb : sa, 0);
                    idle(10);
                end
            end
        end

        // R2: default-latency sequences
        send(OP_LOAD, 1, 0, 1, 0, 0, 0, 2, 1, 1, s, c, sa, sb, t0);
        send(OP_FMUL, 2, 1, 1, 0, 1, 1, 4, 1, 1, s, c, sa, sb, t1);
        chk("R2 load then dependent multiply", s, 1);
        send(OP_LOAD, 2, 0, 1, 0, 0, 0, 6, 1, 1, s, c, sa, sb, t1);
        send(OP_FADD, 4, 1, 1, 6, 1, 1, 8, 1, 1, s, c, sa, sb, t1);
        chk("R2 add after multiply and load", s, MUL_LAT - 2);
        send(OP_STORE, 2, 0, 1, 8, 1, 1, 0, 0, 0, s, c, sa, sb, t1);
        chk("R2 store after add", s, ADD_LAT - 1);
        chk("R3 store data from execute latch", sb, 1);
        idle(10);

        // R5: same-class reuse with independent registers
        for (int u = 0; u < 2; u++) begin
            for (int g = 0; g < 6; g++) begin
                op_e o;
                int lat;
                o = (u == 0) ? OP_FMUL : OP_FADD;
                lat = (u == 0) ? MUL_LAT : ADD_LAT;
                send(o, 2, 1, 1, 3, 1, 1, 4, 1, 1, s, c, sa, sb, t0);
                for (int j = 0; j < g; j++) filler(j);
                send(o, 12, 1, 1, 13, 1, 1, 14, 1, 1, s, c, sa, sb, t1);
                exp_s = lat - (g + 1);
                if (exp_s < 0) exp_s = 0;
                chk("R5 unit reuse stalls", s, exp_s);
                if (exp_s > 0) chk("R7 unit cause", c, 1);
                idle(10);
            end
        end
        send(OP_FMUL, 2, 1, 1, 3, 1, 1, 4, 1, 1, s, c, sa, sb, t0);
        send(OP_FADD, 12, 1, 1, 13, 1, 1, 14, 1, 1, s, c, sa, sb, t1);
        chk("R5 add not blocked by busy multiplier", s, 0);
        idle(10);

        // R6: destination write ordering
        for (int g = 0; g < 5; g++) begin
            send(OP_FMUL, 2, 1, 1, 3, 1, 1, 4, 1, 1, s, c, sa, sb, t0);
            for (int j = 0; j < g; j++) filler(j);
            send(OP_FADD, 12, 1, 1, 13, 1, 1, 4, 1, 1, s, c, sa, sb, t1);
            exp_s = (MUL_LAT + 2) - (ADD_LAT + 2) - g;
            if (exp_s < 0) exp_s = 0;
            chk("R6 add after multiply to same dest", s, exp_s);
            if (exp_s > 0) chk("R7 ordering cause", c, 3);
            idle(10);
        end
        send(OP_FMUL, 2, 1, 1, 3, 1, 1, 4, 1, 1, s, c, sa, sb, t0);
        send(OP_LOAD, 1, 0, 1, 0, 0, 0, 4, 1, 1, s, c, sa, sb, t1);
        chk("R6 load after multiply to same dest", s, MUL_LAT + 2 - 3);
        idle(10);

        // R7: priority between causes
        send(OP_FMUL, 2, 1, 1, 3, 1, 1, 4, 1, 1, s, c, sa, sb, t0);
        send(OP_FMUL, 4, 1, 1, 3, 1, 1, 6, 1, 1, s, c, sa, sb, t1);
        chk("R7 unit outranks source", c, 1);
        idle(10);
        send(OP_FMUL, 2, 1, 1, 3, 1, 1, 4, 1, 1, s, c, sa, sb, t0);
        send(OP_FADD, 4, 1, 1, 3, 1, 1, 4, 1, 1, s, c, sa, sb, t1);
        chk("R7 source outranks ordering", c, 2);
        idle(10);

        // R9: integer register 0
        send(OP_ALU, 3, 0, 1, 0, 0, 0, 0, 0, 1, s, c, sa, sb, t0);
        send(OP_ALU, 0, 0, 1, 0, 0, 0, 7, 0, 1, s, c, sa, sb, t1);
        chk("R9 ALU to r0 then read stalls", s, 0);
        chk("R9 r0 read select", sa, 0);
        send(OP_LOAD, 1, 0, 1, 0, 0, 0, 0, 0, 1, s, c, sa, sb, t0);
        send(OP_STORE, 0, 0, 1, 0, 0, 1, 0, 0, 0, s, c, sa, sb, t1);
        chk("R9 load to r0 then read stalls", s, 0);
        idle(10);

        // R10 R8: invalid instruction, unused dest, store dest fields
        @(negedge clk);
        id_valid = 1'b0; id_op = 3'(OP_FMUL);
        id_src_a = 5'd2; id_src_a_fp = 1; id_src_a_use = 1;
        id_dst = 5'd4; id_dst_fp = 1; id_dst_use = 1;
        #1;
        chk("R8 no stall without valid", int'(stall_id), 0);
        send(OP_FMUL, 2, 1, 1, 3, 1, 1, 9, 1, 1, s, c, sa, sb, t0);
        chk("R10 invalid multiply left unit free", s, 0);
        idle(10);
        send(OP_FADD, 2, 1, 1, 3, 1, 1, 4, 1, 0, s, c, sa, sb, t0);
        send(OP_STORE, 1, 0, 1, 4, 1, 1, 0, 0, 0, s, c, sa, sb, t1);
        chk("R10 unused dest not pending", s, 0);
        chk("R10 unused dest select", sb, 0);
        send(OP_STORE, 1, 0, 1, 2, 1, 1, 5, 1, 1, s, c, sa, sb, t0);
        send(OP_STORE, 1, 0, 1, 5, 1, 1, 0, 0, 0, s, c, sa, sb, t1);
        chk("R10 store dest fields ignored", s, 0);
        idle(10);

        // R1: reset in the middle of a run
        send(OP_FMUL, 2, 1, 1, 3, 1, 1, 4, 1, 1, s, c, sa, sb, t0);
        do_reset();
        send(OP_FMUL, 4, 1, 1, 3, 1, 1, 6, 1, 1, s, c, sa, sb, t1);
        chk("R1 mid-run reset clears state", s, 0);
        chk("R1 mid-run reset select", sa, 0);
        idle(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule